// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block behaves like a word-wide parallel NOR flash that is driven through a command protocol. A host on a plain synchronous bus (byte address, write data, write strobe, read strobe, read data) writes command codes and data words. A small on-chip array, built from a parameterised number of equal sectors, holds the contents. Reads return array data, the status register, identifier codes or query-table bytes. Which of these a read returns depends on the command that is currently latched.

A write-cycle counter, together with the latched command, decides how each bus write is interpreted. The block accepts word program, whole-sector erase with confirm, buffered program (a count, then N+1 data words, then a confirm), status read and clear, identifier read, query read and a lock/unlock handshake. Programming and erasing take effect at once. The `read_only` input turns program and erase attempts into status error flags.

The bus has no back-pressure. A write strobe is consumed in the cycle it is high. A read strobe always yields data one clock later. If both strobes are high in the same cycle, the read sees the state from before the write.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, every array word is all-ones, the status register is 0, `rdata` is 0 and `seq_err` is low.
- R2: `rdata` is loaded on the rising edge at which `rd_en` is high, using the state from before any write in that cycle. It holds its value while `rd_en` is low.
- R3: In array-read mode a first-cycle write of 0xFF, 0xF0, 0x00 or any code other than 0x10, 0x20, 0x40, 0x50, 0x60, 0x70, 0x90, 0x98 or 0xE8 leaves the block in array-read mode and raises no `seq_err`.
- R4: A first-cycle write of 0x10 or 0x40 arms a program. The next write stores `wdata` at word index `addr >> log2(DATA_W/8)` and sets status bit 7. Reads then return the status register, zero-extended.
- R5: When `read_only` is high, the program write stores nothing and sets status bit 4 as well as bit 7.
- R6: A first-cycle write of 0x20 immediately fills every word of the sector that holds the addressed word with all-ones and sets status bit 7. With `read_only` high, no word changes and status bit 5 is set instead. The next write completes the erase if it is 0xD0, aborts to array read if it is 0xFF, and otherwise raises `seq_err` and returns to array read.
- R7: Command 0x70 makes reads return the status register without advancing the cycle counter, so the next write is decoded as a new command. Command 0x50 clears the status register to 0 and returns to array read.
- R8: After command 0x90, reads at word offset 0 return `MFR_ID`, reads at word offset 1 return `DEV_ID`, and reads at any other offset return 0. The word offset is `addr[7:0] >> log2(DATA_W/8)`.
- R9: After command 0x98, reads return query bytes by word offset. 0x10/0x11/0x12 = 0x51/0x52/0x59, 0x13 = 0x01, 0x27 = log2 of the total size in bytes, 0x2C = 0x01, 0x2D/0x2E = low/high byte of SECTORS-1, 0x31/0x32/0x33 = 0x50/0x52/0x49, and every offset at or above 0x52 reads 0. In this mode a write of 0xFF exits to array read, and any other write keeps query mode.
- R10: Command 0xE8 sets status bit 7. The next write gives a count N in `wdata`. The following N+1 writes each store their data at their own word index and set bit 7. After those, a write of 0xD0 completes the sequence and reads keep returning status. Any other value raises `seq_err` and returns to array read.
- R11: Command 0x60 followed by 0xD0 or 0x01 sets status bit 7 and leaves reads returning status. Any other second write returns to array read without `seq_err` and without changing the array.
- R12: `seq_err` is a single-cycle pulse. It is high in the clock cycle after an offending confirm write, and the block is then in array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_only | input | 1 | Blocks program and erase and flags them in status |
| addr | input | ADDR_W | Byte address (word index = addr >> log2(DATA_W/8)) |
| wdata | input | DATA_W | Command code (low 8 bits) or data word |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe, data one clock later |
| rdata | output | DATA_W | Registered read data |
| seq_err | output | 1 | One-cycle pulse on an invalid confirm write |

## Verification
The hardest state to reach is the confirm step of a buffered program. It is only reachable after a command write, a count write and exactly N+1 data writes. The stimulus therefore drives exact counts (3 and 0) and then supplies either the confirm code or a wrong value, checking the `seq_err` pulse and the return to array read. Erase with a wrong confirm gets the same treatment. A bench-side model of the whole array is compared word by word after every program, erase and read-only attempt, including the erase that does take place before a confirm fails.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  // What the latched command says about the meaning of reads and writes
  typedef enum logic [3:0] {
    MD_ARRAY, MD_PROG, MD_ERASE, MD_LOCK, MD_STATUS, MD_BUF, MD_ID, MD_QUERY
  } mode_e;

  // Position inside a multi-write sequence
  typedef enum logic [1:0] {CY_CMD, CY_ARG, CY_DATA, CY_CONF} cycle_e;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_ID, SRC_QUERY} rsrc_e;

  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUF     = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_LOCKDN  = 8'h01;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;

  function automatic rsrc_e source_of(input mode_e m);
    case (m)
      MD_ID:    return SRC_ID;
      MD_QUERY: return SRC_QUERY;
      MD_ARRAY: return SRC_ARRAY;
      default:  return SRC_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
// Command sequencer: cycle counter, latched mode, status register, burst count
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_only,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              prog_en,
  output logic              erase_en,
  output logic [7:0]        status,
  output mode_e             mode,
  output logic              seq_err
);

  logic [7:0]        op;
  mode_e             mode_q, mode_n;
  cycle_e            cyc_q, cyc_n;
  logic [7:0]        stat_q, stat_n;
  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic              err_q, err_n;

  assign op = wdata[7:0];

  always_comb begin
    mode_n   = mode_q;
    cyc_n    = cyc_q;
    stat_n   = stat_q;
    cnt_n    = cnt_q;
    err_n    = 1'b0;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    if (wr_en) begin
      case (cyc_q)
        CY_CMD: begin
          case (op)
            OP_PROG_A, OP_PROG_B: begin
              mode_n = MD_PROG;
              cyc_n  = CY_ARG;
            end
            OP_ERASE: begin
              if (read_only) stat_n[ST_ERASE_ERR] = 1'b1;
              else           erase_en = 1'b1;
              stat_n[ST_READY] = 1'b1;
              mode_n = MD_ERASE;
              cyc_n  = CY_ARG;
            end
            OP_CLR: begin
              stat_n = '0;
              mode_n = MD_ARRAY;
            end
            OP_LOCK: begin
              mode_n = MD_LOCK;
              cyc_n  = CY_ARG;
            end
            OP_STAT:  mode_n = MD_STATUS;
            OP_ID:    mode_n = MD_ID;
            OP_QUERY: begin
              mode_n = MD_QUERY;
              cyc_n  = CY_ARG;
            end
            OP_BUF: begin
              stat_n[ST_READY] = 1'b1;
              mode_n = MD_BUF;
              cyc_n  = CY_ARG;
            end
            default: begin
              mode_n = MD_ARRAY;
              cyc_n  = CY_CMD;
            end
          endcase
        end
        CY_ARG: begin
          case (mode_q)
            MD_PROG: begin
              if (read_only) stat_n[ST_PROG_ERR] = 1'b1;
              else           prog_en = 1'b1;
              stat_n[ST_READY] = 1'b1;
              cyc_n = CY_CMD;
            end
            MD_ERASE: begin
              if (op == OP_CONFIRM) begin
                stat_n[ST_READY] = 1'b1;
                cyc_n = CY_CMD;
              end else begin
                err_n  = (op != OP_ARRAY);
                mode_n = MD_ARRAY;
                cyc_n  = CY_CMD;
              end
            end
            MD_BUF: begin
              cnt_n = wdata;
              cyc_n = CY_DATA;
            end
            MD_LOCK: begin
              if (op == OP_CONFIRM || op == OP_LOCKDN) begin
                stat_n[ST_READY] = 1'b1;
                cyc_n = CY_CMD;
              end else begin
                mode_n = MD_ARRAY;
                cyc_n  = CY_CMD;
              end
            end
            MD_QUERY: begin
              if (op == OP_ARRAY) begin
                mode_n = MD_ARRAY;
                cyc_n  = CY_CMD;
              end
            end
            default: begin
              err_n  = 1'b1;
              mode_n = MD_ARRAY;
              cyc_n  = CY_CMD;
            end
          endcase
        end
        CY_DATA: begin
          if (mode_q == MD_BUF) begin
            if (read_only) stat_n[ST_PROG_ERR] = 1'b1;
            else           prog_en = 1'b1;
            stat_n[ST_READY] = 1'b1;
            if (cnt_q == '0) cyc_n = CY_CONF;
            cnt_n = cnt_q - 1'b1;
          end else begin
            err_n  = 1'b1;
            mode_n = MD_ARRAY;
            cyc_n  = CY_CMD;
          end
        end
        CY_CONF: begin
          if (mode_q == MD_BUF && op == OP_CONFIRM) begin
            stat_n[ST_READY] = 1'b1;
            cyc_n = CY_CMD;
          end else begin
            err_n  = 1'b1;
            mode_n = MD_ARRAY;
            cyc_n  = CY_CMD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_ARRAY;
      cyc_q  <= CY_CMD;
      stat_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cyc_q  <= cyc_n;
      stat_q <= stat_n;
      cnt_q  <= cnt_n;
      err_q  <= err_n;
    end
  end

  assign status  = stat_q;
  assign mode    = mode_q;
  assign seq_err = err_q;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err); // R12
  AST_ERR_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (mode_q == MD_ARRAY && cyc_q == CY_CMD)); // R12
  AST_STATUS_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_STATUS || mode_q == MD_ID) |-> cyc_q == CY_CMD); // R7
  AST_PROG_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == CY_ARG && mode_q == MD_PROG) |=> (stat_q[ST_READY] && cyc_q == CY_CMD)); // R4
  AST_RO_PROG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && read_only && cyc_q == CY_ARG && mode_q == MD_PROG) |=> stat_q[ST_PROG_ERR]); // R5
  AST_CONF_ONLY_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CY_CONF || cyc_q == CY_DATA) |-> mode_q == MD_BUF); // R10
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == CY_CMD && op == OP_CLR) |=> (stat_q == 8'h00 && mode_q == MD_ARRAY)); // R7

endmodule

// File: rtl/flash_word_store.sv
`timescale 1ns/1ps
// Word array with a single-word program port and a whole-sector fill port
module flash_word_store #(
  parameter int DATA_W       = 16,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 32,
  parameter int WIDX_W       = $clog2(SECTORS * SECTOR_WORDS),
  parameter int SEC_W        = $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [WIDX_W-1:0] prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_en,
  input  logic [SEC_W-1:0]  erase_sec,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  localparam int WORDS = SECTORS * SECTOR_WORDS;
  localparam int OFF_W = $clog2(SECTOR_WORDS);

  logic [WORDS-1:0][DATA_W-1:0] cells;

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    localparam logic [SEC_W-1:0]  MY_SEC = SEC_W'(g / SECTOR_WORDS);
    localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(g);
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                cell_q <= '1;
      else if (erase_en && erase_sec == MY_SEC)  cell_q <= '1;
      else if (prog_en && prog_idx == MY_IDX)    cell_q <= prog_data;
    end
    assign cells[g] = cell_q;
  end

  assign rd_word = cells[rd_idx];

  AST_PROG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !erase_en) |=> cells[$past(prog_idx)] == $past(prog_data)); // R4
  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> cells[{$past(erase_sec), {OFF_W{1'b0}}}] == {DATA_W{1'b1}}); // R6

endmodule

// File: rtl/flash_info_rom.sv
`timescale 1ns/1ps
// Identifier codes and query table, computed from the geometry parameters
module flash_info_rom #(
  parameter int          DATA_W       = 16,
  parameter int          SECTORS      = 4,
  parameter int          SECTOR_WORDS = 32,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018
) (
  input  logic [7:0]        off,
  output logic [DATA_W-1:0] id_word,
  output logic [DATA_W-1:0] query_word
);

  localparam int          BYTES     = DATA_W / 8;
  localparam int          TOT_LOG2  = $clog2(SECTORS * SECTOR_WORDS * BYTES);
  localparam int          BUF_LOG2  = (BYTES == 1) ? 8 : 11;
  localparam logic [31:0] SEC_M1    = 32'(SECTORS - 1);
  localparam logic [31:0] SEC_BYTES = 32'(SECTOR_WORDS * BYTES);

  function automatic logic [7:0] qbyte(input logic [7:0] o);
    case (o)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h1F: return 8'h07;
      8'h20: return 8'h07;
      8'h21: return 8'h0A;
      8'h23: return 8'h04;
      8'h24: return 8'h04;
      8'h25: return 8'h04;
      8'h27: return 8'(TOT_LOG2);
      8'h28: return 8'h02;
      8'h2A: return 8'(BUF_LOG2);
      8'h2C: return 8'h01;
      8'h2D: return SEC_M1[7:0];
      8'h2E: return SEC_M1[15:8];
      8'h2F: return SEC_BYTES[15:8];
      8'h30: return SEC_BYTES[23:16];
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      8'h3F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    case (off)
      8'd0:    id_word = DATA_W'(MFR_ID);
      8'd1:    id_word = DATA_W'(DEV_ID);
      default: id_word = '0;
    endcase
  end

  assign query_word = DATA_W'(qbyte(off));

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
// Top: address split, read-source multiplexer and registered read port
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          SECTORS      = 4,
  parameter int          SECTOR_WORDS = 32,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h0018,
  parameter int          ADDR_W       = $clog2(SECTORS * SECTOR_WORDS) + $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_only,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              seq_err
);

  localparam int BSH    = $clog2(DATA_W / 8);
  localparam int WIDX_W = $clog2(SECTORS * SECTOR_WORDS);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int OFF_W  = $clog2(SECTOR_WORDS);

  logic [WIDX_W-1:0] widx;
  logic [7:0]        info_off;
  logic              prog_en, erase_en;
  logic [7:0]        status;
  mode_e             mode;
  logic [DATA_W-1:0] arr_word, id_word, query_word;

  assign widx     = addr[ADDR_W-1:BSH];
  assign info_off = 8'((32'(addr) & 32'hFF) >> BSH);

  flash_cmd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .read_only(read_only),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .status   (status),
    .mode     (mode),
    .seq_err  (seq_err)
  );

  flash_word_store #(
    .DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_en),
    .prog_idx (widx),
    .prog_data(wdata),
    .erase_en (erase_en),
    .erase_sec(widx[WIDX_W-1:OFF_W]),
    .rd_idx   (widx),
    .rd_word  (arr_word)
  );

  flash_info_rom #(
    .DATA_W(DATA_W), .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_info (
    .off       (info_off),
    .id_word   (id_word),
    .query_word(query_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (source_of(mode))
        SRC_ARRAY:  rdata <= arr_word;
        SRC_STATUS: rdata <= DATA_W'(status);
        SRC_ID:     rdata <= id_word;
        SRC_QUERY:  rdata <= query_word;
      endcase
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2
  AST_ERR_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(wr_en)); // R12

endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int DW = 16, SECS = 4, SW = 32, WORDS = SECS * SW;
  localparam logic [15:0] MFR = 16'h0089, DEV = 16'h8816;

  logic clk = 1'b0, rst_n = 1'b0, read_only = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        seq_err;

  int nchk = 0, nerr = 0, pulses = 0;
  bit done = 0;
  logic [15:0] model [WORDS];

  flash_cmd_ctrl #(.DATA_W(DW), .SECTORS(SECS), .SECTOR_WORDS(SW),
                   .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .read_only(read_only), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .seq_err(seq_err));

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n && seq_err === 1'b1) pulses++;

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0123) ^ 16'hA55A);
  endfunction

  function automatic int qexp(input int o);
    case (o)
      8'h10: return 8'h51;  8'h11: return 8'h52;  8'h12: return 8'h59;
      8'h13: return 1;      8'h27: return $clog2(WORDS * 2);
      8'h2C: return 1;      8'h2D: return SECS - 1; 8'h2E: return 0;
      8'h31: return 8'h50;  8'h32: return 8'h52;  8'h33: return 8'h49;
      default: return (o >= 8'h52) ? 0 : -1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] q);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rdata;
  endtask

  task automatic check_all(input string req);
    logic [15:0] q;
    for (int i = 0; i < WORDS; i++) begin
      rd(8'(i * 2), q);
      chk(req, q, model[i]);
    end
  endtask

  task automatic erase_model(input int s);
    for (int i = s * SW; i < (s + 1) * SW; i++) model[i] = 16'hFFFF;
  endtask

  initial begin
    logic [15:0] q;
    int exp_pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_pulses = 0;
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;

    // R1: reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 seq_err", seq_err, 0);
    check_all("R1 erased array");

    // R4: program every word, alternating both program codes
    for (int i = 0; i < WORDS; i++) begin
      wr(8'(i * 2), (i % 2) ? 16'h0040 : 16'h0010);
      wr(8'(i * 2), pat(i));
      model[i] = pat(i);
      if (i < 4) begin
        rd(8'(i * 2), q);
        chk("R4 status after program", q, 16'h0080);
      end
    end
    wr(0, 16'h00FF);
    check_all("R4 programmed array");

    // R2: rdata holds while rd_en is low
    rd(8'd6, q);
    chk("R2 read", q, pat(3));
    addr = 8'h20;
    repeat (3) @(negedge clk);
    chk("R2 hold", rdata, pat(3));

    // R6: erase sector 2 from an address in its middle, confirm
    wr(0, 16'h0050);
    wr(8'd154, 16'h0020);
    erase_model(2);
    rd(0, q);
    chk("R6 status after erase", q, 16'h0080);
    wr(0, 16'h00D0);
    rd(0, q);
    chk("R6 status after confirm", q, 16'h0080);
    wr(0, 16'h00FF);
    check_all("R6 sector 2 erased");
    // R6: abort with 0xFF
    wr(8'd70, 16'h0020);
    erase_model(1);
    wr(0, 16'h00FF);
    rd(8'd70, q);
    chk("R6 abort to array", q, 16'hFFFF);
    // R6, R12: wrong confirm
    wr(8'd200, 16'h0020);
    erase_model(3);
    wr(0, 16'h0033);
    exp_pulses++;
    chk("R12 erase confirm pulse", seq_err, 1);
    @(negedge clk);
    chk("R12 pulse one cycle", seq_err, 0);
    rd(8'd4, q);
    chk("R6 array after bad confirm", q, model[2]);

    // R5: read-only program and erase
    read_only = 1'b1;
    wr(0, 16'h0050);
    wr(8'd10, 16'h0040);
    wr(8'd10, 16'h1234);
    rd(8'd10, q);
    chk("R5 program error status", q, 16'h0090);
    wr(0, 16'h00FF);
    rd(8'd10, q);
    chk("R5 word unchanged", q, model[5]);
    wr(0, 16'h0050);
    wr(8'd0, 16'h0020);
    rd(0, q);
    chk("R6 read-only erase status", q, 16'h00A0);
    wr(0, 16'h00D0);
    wr(0, 16'h00FF);
    rd(0, q);
    chk("R6 read-only erase keeps data", q, model[0]);
    read_only = 1'b0;

    // R7: status read and clear
    wr(0, 16'h0050);
    rd(0, q);
    chk("R7 clear returns to array", q, model[0]);
    wr(0, 16'h0070);
    rd(0, q);
    chk("R7 cleared status", q, 16'h0000);
    wr(0, 16'h0040);
    wr(8'd14, 16'hBEEF);
    model[7] = 16'hBEEF;
    rd(0, q);
    chk("R7 next write decoded as command", q, 16'h0080);
    wr(0, 16'h0050);
    wr(0, 16'h0070);
    rd(0, q);
    chk("R7 status zero after clear", q, 16'h0000);
    wr(0, 16'h00FF);
    rd(8'd14, q);
    chk("R7 word via status sequence", q, 16'hBEEF);

    // R8: identifier sweep over all byte addresses
    wr(0, 16'h0090);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), q);
      chk("R8 identifier", q, (a / 2 == 0) ? MFR : (a / 2 == 1) ? DEV : 16'h0000);
    end
    wr(0, 16'h00FF);

    // R9: query sweep
    wr(0, 16'h0098);
    for (int a = 0; a < 256; a++) begin
      if (qexp(a / 2) >= 0) begin
        rd(8'(a), q);
        chk("R9 query", q, 32'(qexp(a / 2)));
      end
    end
    wr(0, 16'h0000);
    rd(8'h20, q);
    chk("R9 query kept after non-FF", q, 16'h0051);
    wr(0, 16'h00FF);
    rd(0, q);
    chk("R9 exit query", q, model[0]);

    // R10: buffered program, count 3
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    rd(0, q);
    chk("R10 ready after start", q, 16'h0080);
    wr(0, 16'd3);
    for (int k = 0; k < 4; k++) begin
      wr(8'((100 + k) * 2), 16'hC000 + 16'(k));
      model[100 + k] = 16'hC000 + 16'(k);
    end
    wr(0, 16'h00D0);
    rd(0, q);
    chk("R10 status after confirm", q, 16'h0080);
    chk("R10 no error pulse", seq_err, 0);
    wr(0, 16'h00FF);
    // R10: count 0 means one word
    wr(0, 16'h00E8);
    wr(0, 16'd0);
    wr(8'd220, 16'h7777);
    model[110] = 16'h7777;
    wr(0, 16'h00D0);
    wr(0, 16'h00FF);
    check_all("R10 buffered words");
    // R10, R12: bad confirm
    wr(0, 16'h00E8);
    wr(0, 16'd0);
    wr(8'd222, 16'h1111);
    model[111] = 16'h1111;
    wr(0, 16'h0044);
    exp_pulses++;
    chk("R12 buffer confirm pulse", seq_err, 1);
    @(negedge clk);
    chk("R12 pulse one cycle", seq_err, 0);
    rd(8'd222, q);
    chk("R10 array after bad confirm", q, 16'h1111);

    // R11: lock handshake
    wr(0, 16'h0050);
    wr(0, 16'h0060);
    wr(0, 16'h00D0);
    rd(0, q);
    chk("R11 lock D0", q, 16'h0080);
    wr(0, 16'h0050);
    wr(0, 16'h0060);
    wr(0, 16'h0001);
    rd(0, q);
    chk("R11 lock 01", q, 16'h0080);
    wr(0, 16'h0060);
    wr(0, 16'h0077);
    rd(0, q);
    chk("R11 other value to array", q, model[0]);
    wr(0, 16'h0060);
    wr(0, 16'h00FF);
    rd(8'd2, q);
    chk("R11 FF to array", q, model[1]);

    // R3: every unrecognised first-cycle code stays in array read
    for (int v = 0; v < 256; v++) begin
      if (!(v inside {8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70, 8'h90, 8'h98, 8'hE8})) begin
        wr(0, 16'h00FF);
        wr(8'd2, 16'(v));
        rd(8'd2, q);
        chk("R3 array after code", q, model[1]);
      end
    end
    @(negedge clk);
    chk("R12 total error pulses", pulses, exp_pulses);
    check_all("R6 final array");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule